// File: doc/BRIEF.md
# Write Strobe Qualifier

This block sits between the raw chip-select, write-enable and output-enable pins of a non-volatile memory and its page-write sequencer. It lets a write strobe through only when the supply is healthy and has been healthy long enough, when output enable is not holding writes off, and when the strobe has lasted long enough not to be noise. Any strobe that fails one of these tests is dropped for good. The rejection holds for the whole strobe, so a bad strobe never turns into a late or partial write.

The supply-good flag comes from an external comparator. All four inputs pass through a synchronizer of `SYNC_STAGES` flops. A power-up timer arms writing only after the flag has been high for `PU_DELAY` consecutive clock cycles. It restarts from zero whenever the flag drops. A per-strobe filter then requires `MIN_PULSE` consecutive cycles of a valid write condition before it qualifies the strobe. The sequencer sees a level (`wr_gate_o`) for the life of the qualified strobe and a single-cycle start pulse (`wr_fire_o`).

Top module: `wstrobe_guard`

## Requirements
- R1: During and directly after reset, `wr_gate_o` and `wr_fire_o` are 0, and the power-up timer starts from zero with writing disarmed.
- R2: While the synchronized supply-good flag is 0, no strobe is qualified, and `wr_gate_o` is 0 one cycle after the flag is seen low.
- R3: Writing is armed only after the synchronized supply-good flag has been 1 for `PU_DELAY` consecutive cycles. A strobe that lies wholly inside that window produces no `wr_fire_o`.
- R4: A drop of the supply-good flag restarts the power-up delay from zero, so a strobe applied less than `PU_DELAY` cycles after the flag returns is rejected.
- R5: While output enable is low (`oe_n_i` = 0), no strobe is qualified, even with chip select and write enable both low.
- R6: A strobe is only a write condition when `cs_n_i` = 0 and `we_n_i` = 0 together. Either of them held high blocks qualification.
- R7: A write condition lasting fewer than `MIN_PULSE` synchronized cycles produces no `wr_fire_o`. One lasting `MIN_PULSE` or more cycles produces exactly one. The pulse appears `SYNC_STAGES + MIN_PULSE` clock edges after the inputs are applied.
- R8: `wr_fire_o` is a single-cycle pulse that coincides with the rising of `wr_gate_o`. `wr_gate_o` falls on the `SYNC_STAGES + 1`-th edge after the write condition is removed.
- R9: A rejected short strobe does not count toward a following strobe, even when the gap between them is one cycle. Two short strobes give no pulse, and a short strobe followed by a long one gives exactly one.
- R10: A strobe that loses arming while qualified (supply drop) ends at once and is never qualified again, even after arming returns while it is still held.
- R11: A strobe that began while writing was disarmed is never qualified, even when the power-up delay expires while it is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, 1 = above threshold |
| cs_n_i | input | 1 | Raw chip select, active low |
| we_n_i | input | 1 | Raw write enable, active low |
| oe_n_i | input | 1 | Raw output enable, active low; low inhibits writes |
| wr_gate_o | output | 1 | Qualified write strobe level |
| wr_fire_o | output | 1 | One-cycle pulse marking the start of a qualified strobe |

## Verification
The bench builds the block with `SYNC_STAGES` = 2, `MIN_PULSE` = 4 and `PU_DELAY` = 40. These values make the power-up window short enough to cross several times, including a supply drop in the middle of it and a strobe that straddles its end. Strobe lengths are swept from 1 to 8 cycles, which covers both sides of the filter threshold. All eight combinations of the three control pins are applied, and the exact edges where the pulse rises and the gate falls are checked.

// File: rtl/wstrobe_guard_pkg.sv
package wstrobe_guard_pkg;

    // Raw pin bundle, in the order the synchronizer carries it.
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic supply;
    } wsg_pins_t;

    localparam int unsigned PIN_W = $bits(wsg_pins_t);

    // Idle value of every pin: strobes inactive, supply treated as bad.
    localparam wsg_pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, supply: 1'b0};

    // Filter states for one strobe.
    typedef enum logic [1:0] {
        FLT_IDLE  = 2'd0,
        FLT_COUNT = 2'd1,
        FLT_PASS  = 2'd2,
        FLT_SPENT = 2'd3
    } wsg_flt_state_e;

    // Qualified strobe pair delivered to the sequencer.
    typedef struct packed {
        logic gate;
        logic fire;
    } wsg_strobe_t;

    // Width of a counter that must hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Write condition from synchronized pins: both selects low, output enable high.
    function automatic logic write_cond(input wsg_pins_t p);
        return (!p.cs_n) && (!p.we_n) && p.oe_n;
    endfunction

endpackage

// File: rtl/wstrobe_sync.sv
module wstrobe_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] chain_q [STAGES];
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        chain_q[s] <= RST_VAL;
                    end else if (s == 0) begin
                        chain_q[s] <= d_i;
                    end else begin
                        chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
                    end
                end
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/wstrobe_pwr_timer.sv
module wstrobe_pwr_timer
    import wstrobe_guard_pkg::*;
#(
    parameter int unsigned PU_DELAY = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_i,
    output logic armed_o
);

    localparam int unsigned CW = cnt_width(PU_DELAY);
    localparam logic [CW-1:0] LIMIT = CW'(PU_DELAY);

    logic [CW-1:0] cnt_q;

    // Counts consecutive good-supply cycles, saturating at the limit.
    // Any bad-supply cycle sends it back to zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!supply_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // The supply term drops arming in the same cycle the flag is seen low.
    assign armed_o = supply_i && (cnt_q == LIMIT);

endmodule

// File: rtl/wstrobe_pulse_filter.sv
module wstrobe_pulse_filter
    import wstrobe_guard_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cond_i,
    input  logic        armed_i,
    output wsg_strobe_t strobe_o
);

    localparam int unsigned WW = cnt_width(MIN_PULSE);
    localparam logic [WW-1:0] WLIM = WW'(MIN_PULSE);

    wsg_flt_state_e state_q, state_d;
    logic [WW-1:0]  width_q, width_d;
    logic           fire_q, fire_d;

    always_comb begin
        state_d = state_q;
        width_d = width_q;
        unique case (state_q)
            FLT_IDLE: begin
                width_d = '0;
                if (cond_i) begin
                    if (!armed_i) begin
                        state_d = FLT_SPENT;
                    end else if (MIN_PULSE <= 1) begin
                        state_d = FLT_PASS;
                    end else begin
                        state_d = FLT_COUNT;
                        width_d = WW'(1);
                    end
                end
            end
            FLT_COUNT: begin
                if (!cond_i) begin
                    state_d = FLT_IDLE;
                    width_d = '0;
                end else if (!armed_i) begin
                    state_d = FLT_SPENT;
                    width_d = '0;
                end else begin
                    width_d = width_q + WW'(1);
                    if (width_q + WW'(1) == WLIM) begin
                        state_d = FLT_PASS;
                    end
                end
            end
            FLT_PASS: begin
                width_d = '0;
                if (!cond_i) begin
                    state_d = FLT_IDLE;
                end else if (!armed_i) begin
                    state_d = FLT_SPENT;
                end
            end
            FLT_SPENT: begin
                width_d = '0;
                if (!cond_i) begin
                    state_d = FLT_IDLE;
                end
            end
            default: begin
                state_d = FLT_IDLE;
                width_d = '0;
            end
        endcase
    end

    assign fire_d = (state_d == FLT_PASS) && (state_q != FLT_PASS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLT_IDLE;
            width_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            width_q <= width_d;
            fire_q  <= fire_d;
        end
    end

    assign strobe_o.gate = (state_q == FLT_PASS);
    assign strobe_o.fire = fire_q;

endmodule

// File: rtl/wstrobe_guard.sv
module wstrobe_guard
    import wstrobe_guard_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 4,
    parameter int unsigned PU_DELAY    = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic cs_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic wr_gate_o,
    output logic wr_fire_o
);

    wsg_pins_t   pins_raw;
    wsg_pins_t   pins_s;
    logic        supply_s;
    logic        act_s;
    logic        armed;
    wsg_strobe_t strobe;

    assign pins_raw = '{cs_n: cs_n_i, we_n: we_n_i, oe_n: oe_n_i, supply: supply_ok_i};

    wstrobe_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (PIN_W),
        .RST_VAL (PINS_IDLE)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_s)
    );

    assign supply_s = pins_s.supply;
    assign act_s    = write_cond(pins_s);

    wstrobe_pwr_timer #(
        .PU_DELAY (PU_DELAY)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .supply_i (supply_s),
        .armed_o  (armed)
    );

    wstrobe_pulse_filter #(
        .MIN_PULSE (MIN_PULSE)
    ) filter_i (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (act_s),
        .armed_i  (armed),
        .strobe_o (strobe)
    );

    assign wr_gate_o = strobe.gate;
    assign wr_fire_o = strobe.fire;

endmodule

// File: rtl/wstrobe_guard_chk.sv
module wstrobe_guard_chk
    import wstrobe_guard_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 4
) (
    input logic clk,
    input logic rst,
    input logic supply_s,
    input logic act_s,
    input logic armed,
    input logic wr_gate_o,
    input logic wr_fire_o
);

    localparam int unsigned RW = cnt_width(MIN_PULSE);
    localparam logic [RW-1:0] RLIM = RW'(MIN_PULSE);

    // Consecutive cycles of write condition, saturating at the threshold.
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst || !act_s) begin
            run_q <= '0;
        end else if (run_q != RLIM) begin
            run_q <= run_q + RW'(1);
        end
    end

    // R8
    fire_in_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire_o |-> wr_gate_o);

    // R8
    fire_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire_o |=> !wr_fire_o);

    // R8
    gate_rise_fires_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_gate_o) |-> wr_fire_o);

    // R2
    supply_low_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_s |=> !wr_gate_o);

    // R5
    cond_low_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        !act_s |=> !wr_gate_o);

    // R3
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire_o |-> $past(armed));

    // R7
    fire_min_width_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire_o |-> (run_q >= RLIM));

endmodule

bind wstrobe_guard wstrobe_guard_chk #(
    .MIN_PULSE (MIN_PULSE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .supply_s  (supply_s),
    .act_s     (act_s),
    .armed     (armed),
    .wr_gate_o (wr_gate_o),
    .wr_fire_o (wr_fire_o)
);

// File: tb/wstrobe_guard_tb_top.sv
`timescale 1ns/1ps
module wstrobe_guard_tb_top;

    localparam int SYNC = 2;
    localparam int MINP = 4;
    localparam int PU   = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic cs_n = 1'b1;
    logic we_n = 1'b1;
    logic oe_n = 1'b1;
    logic wr_gate;
    logic wr_fire;

    int n_chk  = 0;
    int n_fail = 0;
    int fires  = 0;

    always #10 clk = ~clk;

    wstrobe_guard #(
        .SYNC_STAGES (SYNC),
        .MIN_PULSE   (MINP),
        .PU_DELAY    (PU)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (supply_ok),
        .cs_n_i      (cs_n),
        .we_n_i      (we_n),
        .oe_n_i      (oe_n),
        .wr_gate_o   (wr_gate),
        .wr_fire_o   (wr_fire)
    );

    always @(negedge clk) begin
        if (!rst && wr_fire) fires++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic c, input logic w, input logic o);
        cs_n = c; we_n = w; oe_n = o;
    endtask

    // Hold a write condition for len edges, release, then let it settle.
    task automatic pulse(input int len);
        drive(1'b0, 1'b0, 1'b1);
        step(len);
        drive(1'b1, 1'b1, 1'b1);
        step(SYNC + 4);
    endtask

    task automatic arm();
        supply_ok = 1'b1;
        step(SYNC + PU + 4);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int f0;
        // R1: reset state
        step(4);
        chk("R1 gate in reset", wr_gate, 0);
        chk("R1 fire in reset", wr_fire, 0);
        rst = 1'b0;
        step(1);
        chk("R1 gate after reset", wr_gate, 0);
        chk("R1 fire after reset", wr_fire, 0);

        // R2: supply low blocks a long strobe
        f0 = fires;
        pulse(12);
        chk("R2 supply low", fires - f0, 0);

        // R11: strobe started while disarmed, delay expires under it
        f0 = fires;
        supply_ok = 1'b1;
        drive(1'b0, 1'b0, 1'b1);
        step(SYNC + PU + 12);
        chk("R11 gate stays low", wr_gate, 0);
        drive(1'b1, 1'b1, 1'b1);
        step(SYNC + 4);
        chk("R11 no fire", fires - f0, 0);

        // R3: strobe inside power-up window
        supply_ok = 1'b0;
        step(6);
        supply_ok = 1'b1;
        step(PU - 14);
        f0 = fires;
        pulse(6);
        chk("R3 inside delay", fires - f0, 0);
        step(12);
        f0 = fires;
        pulse(8);
        chk("R3 after delay", fires - f0, 1);

        // R4: drop restarts the delay
        supply_ok = 1'b0;
        step(3);
        supply_ok = 1'b1;
        step(PU - 14);
        f0 = fires;
        pulse(6);
        chk("R4 restarted delay", fires - f0, 0);
        step(20);
        f0 = fires;
        pulse(8);
        chk("R4 rearmed", fires - f0, 1);

        // R5, R6: all pin combinations held for 8 edges
        for (int k = 0; k < 8; k++) begin
            logic c, w, o;
            int exp;
            c = k[2]; w = k[1]; o = k[0];
            exp = (!c && !w && o) ? 1 : 0;
            f0 = fires;
            drive(c, w, o);
            step(8);
            drive(1'b1, 1'b1, 1'b1);
            step(SYNC + 4);
            if (!o) chk("R5 output enable low", fires - f0, exp);
            else    chk("R6 select combo", fires - f0, exp);
        end

        // R7: width sweep around the threshold
        for (int len = 1; len <= 8; len++) begin
            f0 = fires;
            pulse(len);
            chk("R7 width sweep", fires - f0, (len >= MINP) ? 1 : 0);
        end

        // R7, R8: exact edges of fire and gate
        drive(1'b0, 1'b0, 1'b1);
        step(SYNC + MINP - 1);
        chk("R7 gate before threshold", wr_gate, 0);
        step(1);
        chk("R7 fire at threshold", wr_fire, 1);
        chk("R8 gate with fire", wr_gate, 1);
        step(1);
        chk("R8 fire one cycle", wr_fire, 0);
        chk("R8 gate held", wr_gate, 1);
        step(3);
        drive(1'b1, 1'b1, 1'b1);
        step(SYNC);
        chk("R8 gate before fall", wr_gate, 1);
        step(1);
        chk("R8 gate fallen", wr_gate, 0);
        step(4);

        // R9: short strobes do not accumulate
        f0 = fires;
        drive(1'b0, 1'b0, 1'b1); step(3);
        drive(1'b1, 1'b1, 1'b1); step(1);
        pulse(3);
        chk("R9 two short", fires - f0, 0);
        f0 = fires;
        drive(1'b0, 1'b0, 1'b1); step(2);
        drive(1'b1, 1'b1, 1'b1); step(1);
        pulse(6);
        chk("R9 short then long", fires - f0, 1);

        // R10: arming lost during a qualified strobe
        f0 = fires;
        drive(1'b0, 1'b0, 1'b1);
        step(SYNC + MINP + 1);
        chk("R10 gate up", wr_gate, 1);
        supply_ok = 1'b0;
        step(SYNC + 1);
        chk("R10 gate dropped", wr_gate, 0);
        supply_ok = 1'b1;
        step(SYNC + PU + 10);
        chk("R10 no requalify gate", wr_gate, 0);
        drive(1'b1, 1'b1, 1'b1);
        step(SYNC + 4);
        chk("R10 single fire", fires - f0, 1);

        arm();
        f0 = fires;
        pulse(MINP);
        chk("R7 rearmed at threshold", fires - f0, 1);

        summary();
    end

endmodule